// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by consulting a linear page table that lives in ordinary memory. A requester presents a virtual address together with a flag that marks the access as a read or a write. The block also receives the current table base and entry-count registers. It handles one request at a time. For each request it first compares the page number with the entry count, then reads one table entry through a simple memory port and examines it. The result is a single-cycle response that carries either the physical address or a fault with a cause code.

When a translation succeeds, the block records the access in the entry itself. The use bit is always set, and a write also sets the modified bit. The updated word is stored back to the address it was read from, but only if one of those bits actually changes. No write-back happens on a fault. Software can then rely on the table contents to see which pages were touched or dirtied.

Top module: `pt_walker`

## Requirements
- R1: On success, `resp_paddr` equals the entry's frame number (entry bits 31:12) placed above the unchanged low 12 bits of the virtual address, with `resp_fault` low.
- R2: If the page number (virtual address bits 31:12) is greater than or equal to `pt_len`, the response is a fault with cause 0 (bounds) and no memory request of any kind is made for that translation.
- R3: The entry read goes to `pt_base + 4 * page number`, and `mem_addr` and `mem_we` stay unchanged while `mem_req` waits for `mem_gnt`.
- R4: An entry whose valid bit (bit 0) is clear gives a fault with cause 1 (invalid), whatever its present bit holds.
- R5: A valid entry whose present bit (bit 1) is clear gives a fault with cause 2 (not present).
- R6: A write to a valid, present entry with its read-only bit (bit 2) set gives a fault with cause 3 (protection), and a read of the same entry succeeds.
- R7: After a successful translation the stored entry has its use bit (bit 3) set, and after a successful write it also has its modified bit (bit 4) set. All other bits are unchanged, and the new word goes to the same address that was read.
- R8: No memory write is made after a faulting translation, or after a success in which the use bit, and for writes also the modified bit, were already set.
- R9: Only one translation is in flight: `req_ready` falls in the cycle after acceptance and stays low until the response. `resp_valid` is a one-cycle pulse, and `resp_vaddr` returns the accepted virtual address.
- R10: After reset, `req_ready` is high and `resp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted on this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| pt_base | input | 32 | Byte address of entry 0 of the table |
| pt_len | input | 32 | Number of entries in the table |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Response is a fault |
| resp_cause | output | 2 | Fault cause: 0 bounds, 1 invalid, 2 not present, 3 protection |
| resp_paddr | output | 32 | Physical address (meaningful when no fault) |
| resp_vaddr | output | 32 | Virtual address of the translation being answered |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for entry write-back, 0 for entry read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench probes the edge of the bounds check: a page number equal to the length must fault without touching memory, and one just below it must translate. An off-by-one compare would either fetch beyond the table or reject its last entry. It builds entries that are invalid but present and entries that are valid but absent, so that a swapped priority would report the wrong cause. It also writes to read-only pages, where a design that checked protection too late would dirty the entry anyway. Repeated writes to a page that is already marked used and modified expose a design that always writes back, because the bench counts memory writes. Randomly stalled grants catch an address that changes while a request is still waiting for its grant.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    parameter int unsigned ADDR_W    = 32;
    parameter int unsigned OFF_W     = 12;
    parameter int unsigned PTE_SHIFT = 2;
    localparam int unsigned VPN_W    = ADDR_W - OFF_W;
    localparam int unsigned FLAG_W   = 5;
    localparam int unsigned RSVD_W   = OFF_W - FLAG_W;

    typedef enum logic [1:0] {
        CAUSE_BOUNDS  = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_ABSENT  = 2'd2,
        CAUSE_WPROT   = 2'd3
    } cause_e;

    typedef struct packed {
        logic [VPN_W-1:0]  frame;
        logic [RSVD_W-1:0] rsvd;
        logic              modified;
        logic              used;
        logic              rdonly;
        logic              present;
        logic              valid;
    } pte_t;

    typedef struct packed {
        logic              fault;
        cause_e            cause;
        logic [ADDR_W-1:0] paddr;
        logic              wb;
        pte_t              wdata;
    } verdict_t;

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [ADDR_W-1:0] base,
        input logic [VPN_W-1:0]  vpn
    );
        return base + (ADDR_W'(vpn) << PTE_SHIFT);
    endfunction

endpackage

// File: rtl/ptw_bounds.sv
module ptw_bounds
    import ptw_pkg::*;
(
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    output logic              out_of_range,
    output logic [ADDR_W-1:0] eaddr
);
    always_comb begin
        out_of_range = ADDR_W'(vpn) >= len;
        eaddr        = entry_addr(base, vpn);
    end
endmodule

// File: rtl/ptw_check.sv
module ptw_check
    import ptw_pkg::*;
(
    input  pte_t             entry,
    input  logic             is_write,
    input  logic [OFF_W-1:0] offset,
    output verdict_t         verdict
);
    pte_t upd;

    always_comb begin
        upd          = entry;
        upd.used     = 1'b1;
        upd.modified = entry.modified | is_write;

        verdict       = '0;
        verdict.paddr = {entry.frame, offset};
        verdict.wdata = upd;
        if (!entry.valid) begin
            verdict.fault = 1'b1;
            verdict.cause = CAUSE_INVALID;
        end else if (!entry.present) begin
            verdict.fault = 1'b1;
            verdict.cause = CAUSE_ABSENT;
        end else if (is_write && entry.rdonly) begin
            verdict.fault = 1'b1;
            verdict.cause = CAUSE_WPROT;
        end else begin
            verdict.fault = 1'b0;
            verdict.cause = CAUSE_BOUNDS;
            verdict.wb    = (upd != entry);
        end
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              oob_in,
    input  logic [ADDR_W-1:0] eaddr_in,
    input  verdict_t          vd_in,
    output logic              wr_flag,
    output logic [OFF_W-1:0]  va_offset,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [1:0]        resp_cause,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [ADDR_W-1:0] resp_vaddr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_RESP
    } state_e;

    state_e            st;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic [ADDR_W-1:0] ea_q;
    logic              flt_q;
    cause_e            cause_q;
    logic [ADDR_W-1:0] paddr_q;
    pte_t              wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            ea_q    <= '0;
            flt_q   <= 1'b0;
            cause_q <= CAUSE_BOUNDS;
            paddr_q <= '0;
            wdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_vaddr;
                        wr_q  <= req_write;
                        ea_q  <= eaddr_in;
                        flt_q <= oob_in;
                        cause_q <= CAUSE_BOUNDS;
                        paddr_q <= '0;
                        st    <= oob_in ? ST_RESP : ST_RD_REQ;
                    end
                end
                ST_RD_REQ: if (mem_gnt) st <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (mem_rvalid) begin
                        flt_q   <= vd_in.fault;
                        cause_q <= vd_in.cause;
                        paddr_q <= vd_in.paddr;
                        wdata_q <= vd_in.wdata;
                        st <= (!vd_in.fault && vd_in.wb) ? ST_WR_REQ : ST_RESP;
                    end
                end
                ST_WR_REQ: if (mem_gnt) st <= ST_RESP;
                ST_RESP:   st <= ST_IDLE;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = (st == ST_IDLE);
        mem_req    = (st == ST_RD_REQ) || (st == ST_WR_REQ);
        mem_we     = (st == ST_WR_REQ);
        mem_addr   = ea_q;
        mem_wdata  = wdata_q;
        resp_valid = (st == ST_RESP);
        resp_fault = flt_q;
        resp_cause = cause_q;
        resp_paddr = paddr_q;
        resp_vaddr = va_q;
        wr_flag    = wr_q;
        va_offset  = va_q[OFF_W-1:0];
    end

    p_bounds_nomem_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && oob_in) |=> !mem_req);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_wb_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[3] && (mem_wdata[4] || !wr_flag)));

    p_no_wb_fault_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !resp_fault);

    p_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] pt_base,
    input  logic [ADDR_W-1:0] pt_len,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [1:0]        resp_cause,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [ADDR_W-1:0] resp_vaddr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata
);
    logic              oob;
    logic [ADDR_W-1:0] eaddr;
    verdict_t          vd;
    logic              wr_flag;
    logic [OFF_W-1:0]  va_offset;

    ptw_bounds u_bounds (
        .vpn          (req_vaddr[ADDR_W-1:OFF_W]),
        .base         (pt_base),
        .len          (pt_len),
        .out_of_range (oob),
        .eaddr        (eaddr)
    );

    ptw_check u_check (
        .entry    (pte_t'(mem_rdata)),
        .is_write (wr_flag),
        .offset   (va_offset),
        .verdict  (vd)
    );

    ptw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .oob_in     (oob),
        .eaddr_in   (eaddr),
        .vd_in      (vd),
        .wr_flag    (wr_flag),
        .va_offset  (va_offset),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .resp_cause (resp_cause),
        .resp_paddr (resp_paddr),
        .resp_vaddr (resp_vaddr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid)
    );
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] pt_base = 32'h0004_0000;
    logic [31:0] pt_len = 32'd8;
    logic        resp_valid, resp_fault;
    logic [1:0]  resp_cause;
    logic [31:0] resp_paddr, resp_vaddr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        gnt_en = 1'b1;

    logic [31:0] pt [64];
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign mem_gnt = mem_req & gnt_en;

    pt_walker u_dut (.*);

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                pt[6'((mem_addr - pt_base) >> 2)] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
                last_wr_addr <= mem_addr;
            end else begin
                mem_rvalid   <= 1'b1;
                mem_rdata    <= pt[6'((mem_addr - pt_base) >> 2)];
                rd_cnt       <= rd_cnt + 1;
                last_rd_addr <= mem_addr;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            gnt_en = ($urandom % 4) != 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements
    task automatic expect_of(input logic [31:0] pte, input logic wr, input logic [19:0] vpn,
                             input logic [31:0] len, input logic [11:0] off,
                             output logic flt, output logic [1:0] cause,
                             output logic [31:0] pa, output logic [31:0] new_pte,
                             output int nrd, output int nwr);
        flt = 1'b0; cause = 2'd0; pa = {pte[31:12], off}; new_pte = pte; nrd = 1; nwr = 0;
        if ({12'd0, vpn} >= len) begin
            flt = 1'b1; cause = 2'd0; nrd = 0;
        end else if (!pte[0]) begin
            flt = 1'b1; cause = 2'd1;
        end else if (!pte[1]) begin
            flt = 1'b1; cause = 2'd2;
        end else if (wr && pte[2]) begin
            flt = 1'b1; cause = 2'd3;
        end else begin
            new_pte = pte | 32'h8 | (wr ? 32'h10 : 32'h0);
            nwr = (new_pte != pte) ? 1 : 0;
        end
    endtask

    task automatic run_one(input logic [31:0] va, input logic wr, input string tag);
        logic        e_flt; logic [1:0] e_cause; logic [31:0] e_pa, e_pte, old_pte;
        int          e_rd, e_wr, rd0, wr0, waited;
        logic [19:0] vpn;
        vpn = va[31:12];
        old_pte = pt[6'(vpn)];
        expect_of(old_pte, wr, vpn, pt_len, va[11:0], e_flt, e_cause, e_pa, e_pte, e_rd, e_wr);
        while (!req_ready) @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9", {tag, " busy after accept"}, 32'(req_ready), 32'd0);
        waited = 0;
        while (!resp_valid && waited < 200) begin
            @(negedge clk); waited++;
            if (!resp_valid) chk(!req_ready, "R9", {tag, " busy while pending"}, 32'(req_ready), 32'd0);
        end
        chk(resp_valid, "R9", {tag, " response arrived"}, 32'(resp_valid), 32'd1);
        chk(resp_fault == e_flt, e_flt ? "R2" : "R1", {tag, " fault flag"}, 32'(resp_fault), 32'(e_flt));
        if (e_flt)
            chk(resp_cause == e_cause, "R4", {tag, " cause (R2/R4/R5/R6)"}, 32'(resp_cause), 32'(e_cause));
        else
            chk(resp_paddr == e_pa, "R1", {tag, " paddr"}, resp_paddr, e_pa);
        chk(resp_vaddr == va, "R9", {tag, " vaddr"}, resp_vaddr, va);
        chk(rd_cnt - rd0 == e_rd, "R2", {tag, " reads"}, 32'(rd_cnt - rd0), 32'(e_rd));
        if (e_rd == 1)
            chk(last_rd_addr == pt_base + {10'd0, vpn, 2'b00}, "R3", {tag, " entry addr"},
                last_rd_addr, pt_base + {10'd0, vpn, 2'b00});
        chk(wr_cnt - wr0 == e_wr, "R8", {tag, " writes"}, 32'(wr_cnt - wr0), 32'(e_wr));
        if (e_wr == 1)
            chk(last_wr_addr == last_rd_addr, "R7", {tag, " wb addr"}, last_wr_addr, last_rd_addr);
        chk(pt[6'(vpn)] == e_pte, "R7", {tag, " entry after"}, pt[6'(vpn)], e_pte);
        @(negedge clk);
        chk(!resp_valid, "R9", {tag, " single pulse"}, 32'(resp_valid), 32'd0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        for (int i = 0; i < 64; i++) pt[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready, "R10", "ready after reset", 32'(req_ready), 32'd1);
        chk(!resp_valid, "R10", "resp idle after reset", 32'(resp_valid), 32'd0);
        chk(!mem_req, "R10", "mem idle after reset", 32'(mem_req), 32'd0);

        pt_base = 32'h0004_0000; pt_len = 32'd8;
        pt[8] = 32'hFFFF_F003;
        pt[7] = 32'hABCD_E003;
        pt[1] = 32'h1234_5002;          // R4: invalid, present set
        pt[2] = 32'h2222_2001;          // R5: valid, absent
        pt[3] = 32'h3333_3007;          // R6: read-only
        pt[4] = 32'h4444_4003;
        run_one(32'h0000_8ABC, 1'b0, "R2 vpn==len");
        run_one(32'h0000_7123, 1'b0, "R1 last entry read");
        run_one(32'h0000_1FFF, 1'b0, "R4 invalid");
        run_one(32'h0000_2010, 1'b1, "R5 absent");
        run_one(32'h0000_3444, 1'b1, "R6 write ro");
        run_one(32'h0000_3444, 1'b0, "R6 read ro");
        run_one(32'h0000_4008, 1'b1, "R7 first write");
        run_one(32'h0000_4008, 1'b1, "R8 repeat write");
        run_one(32'h0000_4008, 1'b0, "R8 read used");

        for (int i = 0; i < 300; i++) begin
            logic [19:0] vpn;
            pt_base = {12'd0, 8'($urandom), 12'd0};
            pt_len  = 32'(1 + $urandom % 48);
            vpn     = 20'($urandom % 56);
            pt[6'(vpn)] = {20'($urandom), 7'd0, 5'($urandom)};
            run_one({vpn, 12'($urandom)}, 1'($urandom), "R3 random");
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule